// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the serial front end and data path of a small byte-wide nonvolatile memory. An external controller talks to it over a four-wire serial link in clock mode 0 or mode 3. The block decodes an 8-bit command, collects a 16-bit address where the command has one, and streams bytes into or out of a 4096 x 8 array. The serial pins are sampled by a faster system clock: every line goes through a synchronizer, and rising and falling serial clock edges are detected in the system clock domain.

Array writes collect in a 32-byte page buffer. The buffer is copied into the array after a self-timed programming cycle, whose length is a parameter counted in system clock cycles. A neighbouring status and protection block owns the write-enable latch, the flag bit and the protection settings. This engine sends that block one-cycle strobes for latch set, latch clear/flag clear, flag set and status write. The neighbour answers with the latch state and two permission inputs: one for status writes and one for the page at the captured write address.

Top module: `eep_cmd_engine`

## Requirements
- R1: Command codes (MSB first): 0x06 pulses `wel_set`, 0x04 pulses `latch_clr`, 0x00 pulses `flag_set`. Each pulse fires only when chip select rises after exactly eight clocked bits. Any extra or missing bit cancels the pulse.
- R2: `spi_so_en` is low whenever chip select is high, so the data output can be left undriven.
- R3: Command 0x05 returns the status byte `{stat_in[6:0], busy}` MSB first, with the busy flag in bit 0. The byte repeats for as long as clocks continue.
- R4: Command 0x03 takes a 16-bit address, MSB first. Bits 15..12 are ignored. It then streams array bytes from that address, incrementing after each byte, and wraps from 0xFFF to 0x000.
- R5: Command 0x02 takes a 16-bit address and one or more data bytes. The in-page offset (address bits 4..0) increments after each byte and wraps within the 32-byte page, so a later byte overwrites an earlier one at the same offset.
- R6: A write starts a programming cycle only if chip select rises with no partial byte pending and at least one data byte received. Otherwise the array is left unchanged and `busy` stays low.
- R7: An array write made while `wel_in` is low, or while `pg_wr_ok` is low for the captured address `pg_chk_addr`, is dropped without a programming cycle.
- R8: After a committed write, `busy` is high for exactly `WC_CYCLES` clock cycles and `cyc_done` pulses once. The new data is readable afterwards.
- R9: While `busy` is high, every command other than 0x05 is ignored, and no strobe fires.
- R10: Command 0x01 followed by one data byte pulses `sts_wr` with that byte on `sts_wdata` and starts a programming cycle. This happens only when `wel_in` and `sts_wr_ok` are high and chip select rises on the byte boundary.
- R11: After reset, no command is accepted until chip select has been seen falling.
- R12: The serial data output changes only after a detected falling edge of the serial clock. This holds in both clock mode 0 and mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for spi_so |
| stat_in | input | 7 | Status bits 7..1 from the status block |
| wel_in | input | 1 | Write-enable latch state |
| sts_wr_ok | input | 1 | Status writes permitted |
| pg_wr_ok | input | 1 | Page at pg_chk_addr is writable |
| pg_chk_addr | output | ADDR_W | Captured write start address |
| wel_set | output | 1 | Strobe: set write-enable latch |
| latch_clr | output | 1 | Strobe: clear write-enable latch and flag |
| flag_set | output | 1 | Strobe: set flag bit |
| sts_wr | output | 1 | Strobe: write status byte |
| sts_wdata | output | 8 | Status byte to write |
| busy | output | 1 | Programming cycle in progress |
| cyc_done | output | 1 | Pulse at the end of a programming cycle |

## Verification
A wrong bit counter or command state shows up at the strobe ports on the next chip-select rise: a pulse that should not fire, or one that goes missing. A wrong address pointer or page-offset wrap stays hidden until the next read, which returns a byte from the wrong location one serial byte after the address. Errors in the programming timer appear on `busy` as a wrong cycle count. Errors in the busy gating show up as strobes or programming cycles during a cycle that is already running.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_RDAT, ST_RSR, ST_WDAT, ST_SRD, ST_PEND, ST_IGN
  } eep_st_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_SFLB  = 8'h00;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // linear increment that wraps at 2**aw
  function automatic logic [15:0] lin_next(input logic [15:0] a, input int aw);
    return (a + 16'd1) & ((16'd1 << aw) - 16'd1);
  endfunction

  // increment of the low pw bits only, upper bits kept
  function automatic logic [15:0] pg_next(input logic [15:0] a, input int pw);
    logic [15:0] m;
    m = (16'd1 << pw) - 16'd1;
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction
endpackage

// File: rtl/eep_spi_front.sv
module eep_spi_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic cs_high,
  output logic si_s
);
  logic [SYNC:0]   sck_p, cs_p;
  logic [SYNC-1:0] si_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '0;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], sck};
      cs_p  <= {cs_p[SYNC-1:0], cs_n};
      si_p  <= {si_p[SYNC-2:0], si};
    end
  end

  assign sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  assign sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC];
  assign cs_rise  = cs_p[SYNC-1] & ~cs_p[SYNC];
  assign cs_fall  = ~cs_p[SYNC-1] & cs_p[SYNC];
  assign cs_high  = cs_p[SYNC-1];
  assign si_s     = si_p[SYNC-1];
endmodule

// File: rtl/eep_wc_timer.sv
module eep_wc_timer #(
  parameter int WC_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WC_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= CW'(WC_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_off,
  input  logic [7:0]               buf_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pval <= '0;
    else if (buf_clr) pval <= '0;
    else if (buf_we)  pval[buf_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_off] <= buf_data;
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pval[i]) mem[{page_sel, PAGE_W'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              si_s,
  input  logic              busy,
  input  logic              wc_done,
  input  logic [6:0]        stat_in,
  input  logic              wel_in,
  input  logic              sts_wr_ok,
  input  logic              pg_wr_ok,
  output logic              so_d,
  output logic              so_en,
  output logic              wel_set,
  output logic              latch_clr,
  output logic              flag_set,
  output logic              sts_wr,
  output logic [7:0]        sts_wdata,
  output logic              wc_start,
  output logic              arr_commit,
  output logic [ADDR_W-1:0] pg_chk_addr,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_off,
  output logic [7:0]        buf_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  eep_st_e           st;
  logic [2:0]        bit_cnt;
  logic [6:0]        sh;
  logic [7:0]        op, tx_next, out_sh;
  logic [ADDR_W-9:0] a_hi;
  logic              is_wr, got_byte, load_pend, arr_cyc;
  logic [ADDR_W-1:0] rd_ptr, wr_base;
  logic [PAGE_W-1:0] wr_off;

  // named internal events
  logic [7:0]        byte_in;
  logic              byte_done;
  logic [ADDR_W-1:0] addr_now, rd_next;

  assign byte_in    = {sh, si_s};
  assign byte_done  = sck_rise && (st != ST_IDLE) && (bit_cnt == 3'd7);
  assign addr_now   = {a_hi, byte_in};
  assign rd_addr    = (st == ST_ALO) ? addr_now : rd_ptr;
  assign rd_next    = ADDR_W'(lin_next(16'(rd_addr), ADDR_W));
  assign buf_clr    = byte_done && (st == ST_ALO) && is_wr;
  assign buf_we     = byte_done && (st == ST_WDAT);
  assign buf_off    = wr_off;
  assign buf_data   = byte_in;
  assign pg_chk_addr = wr_base;
  assign arr_commit = wc_done && arr_cyc;
  assign so_d       = out_sh[7];
  assign so_en      = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bit_cnt <= '0; sh <= '0; op <= '0; a_hi <= '0;
      tx_next <= '0; out_sh <= '0; is_wr <= 1'b0; got_byte <= 1'b0;
      load_pend <= 1'b0; arr_cyc <= 1'b0; rd_ptr <= '0; wr_base <= '0;
      wr_off <= '0; sts_wdata <= '0;
      wel_set <= 1'b0; latch_clr <= 1'b0; flag_set <= 1'b0;
      sts_wr <= 1'b0; wc_start <= 1'b0;
    end else begin
      wel_set <= 1'b0; latch_clr <= 1'b0; flag_set <= 1'b0;
      sts_wr <= 1'b0; wc_start <= 1'b0;
      if (cs_fall) begin
        st <= ST_OPC; bit_cnt <= '0; got_byte <= 1'b0; load_pend <= 1'b0;
      end else if (cs_rise) begin
        st <= ST_IDLE;
        if (bit_cnt == 3'd0) begin
          if (st == ST_PEND) begin
            case (op)
              OP_WREN: wel_set   <= 1'b1;
              OP_WRDI: latch_clr <= 1'b1;
              OP_SFLB: flag_set  <= 1'b1;
              OP_WRSR: if (wel_in && sts_wr_ok) begin
                sts_wr <= 1'b1; wc_start <= 1'b1; arr_cyc <= 1'b0;
              end
              default: ;
            endcase
          end
          if (st == ST_WDAT && got_byte && wel_in && pg_wr_ok) begin
            wc_start <= 1'b1; arr_cyc <= 1'b1;
          end
        end
      end else if (sck_rise && st != ST_IDLE) begin
        bit_cnt <= bit_cnt + 3'd1;
        sh      <= byte_in[6:0];
        if (st == ST_PEND) st <= ST_IGN;
        else if (bit_cnt == 3'd7) begin
          case (st)
            ST_OPC: begin
              op <= byte_in;
              if (busy && byte_in != OP_RDSR) st <= ST_IGN;
              else begin
                case (byte_in)
                  OP_WREN, OP_WRDI, OP_SFLB: st <= ST_PEND;
                  OP_RDSR: begin
                    tx_next <= {stat_in, busy}; load_pend <= 1'b1; st <= ST_RSR;
                  end
                  OP_WRSR:  st <= ST_SRD;
                  OP_READ:  begin is_wr <= 1'b0; st <= ST_AHI; end
                  OP_WRITE: begin is_wr <= 1'b1; st <= ST_AHI; end
                  default:  st <= ST_IGN;
                endcase
              end
            end
            ST_AHI: begin a_hi <= byte_in[ADDR_W-9:0]; st <= ST_ALO; end
            ST_ALO: begin
              if (is_wr) begin
                wr_base <= addr_now; wr_off <= addr_now[PAGE_W-1:0]; st <= ST_WDAT;
              end else begin
                tx_next <= rd_data; load_pend <= 1'b1; rd_ptr <= rd_next; st <= ST_RDAT;
              end
            end
            ST_RDAT: begin tx_next <= rd_data; load_pend <= 1'b1; rd_ptr <= rd_next; end
            ST_RSR:  begin tx_next <= {stat_in, busy}; load_pend <= 1'b1; end
            ST_WDAT: begin
              got_byte <= 1'b1;
              wr_off   <= PAGE_W'(pg_next(16'(wr_off), PAGE_W));
            end
            ST_SRD:  begin sts_wdata <= byte_in; st <= ST_PEND; end
            default: ;
          endcase
        end
      end else if (sck_fall && st != ST_IDLE) begin
        if (load_pend) begin out_sh <= tx_next; load_pend <= 1'b0; end
        else out_sh <= {out_sh[6:0], 1'b0};
      end
    end
  end

  // R9
  quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wel_set || latch_clr || flag_set || sts_wr));
  // R12
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_d) |-> $past(sck_fall));
  // R7
  start_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wc_start |-> $past(wel_in));
  // R10
  sts_wr_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> ($past(sts_wr_ok) && $past(wel_in)));
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WC_CYCLES = 400,
  parameter int SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_en,
  input  logic [6:0]        stat_in,
  input  logic              wel_in,
  input  logic              sts_wr_ok,
  input  logic              pg_wr_ok,
  output logic [ADDR_W-1:0] pg_chk_addr,
  output logic              wel_set,
  output logic              latch_clr,
  output logic              flag_set,
  output logic              sts_wr,
  output logic [7:0]        sts_wdata,
  output logic              busy,
  output logic              cyc_done
);
  logic sck_rise, sck_fall, cs_rise, cs_fall, cs_high, si_s;
  logic wc_start, arr_commit, buf_clr, buf_we;
  logic [PAGE_W-1:0] buf_off;
  logic [7:0]        buf_data, rd_data;
  logic [ADDR_W-1:0] rd_addr;

  eep_spi_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .cs_high(cs_high), .si_s(si_s));

  eep_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wc_start), .busy(busy), .done(cyc_done));

  eep_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .si_s(si_s), .busy(busy),
    .wc_done(cyc_done), .stat_in(stat_in), .wel_in(wel_in),
    .sts_wr_ok(sts_wr_ok), .pg_wr_ok(pg_wr_ok), .so_d(spi_so), .so_en(spi_so_en),
    .wel_set(wel_set), .latch_clr(latch_clr), .flag_set(flag_set),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .wc_start(wc_start),
    .arr_commit(arr_commit), .pg_chk_addr(pg_chk_addr), .buf_clr(buf_clr),
    .buf_we(buf_we), .buf_off(buf_off), .buf_data(buf_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_off(buf_off), .buf_data(buf_data), .commit(arr_commit),
    .page_sel(pg_chk_addr[ADDR_W-1:PAGE_W]), .rd_addr(rd_addr), .rd_data(rd_data));

  // R2
  so_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_high && $past(cs_high)) |-> !spi_so_en);
endmodule

// File: tb/eep_cmd_engine_tb.sv
module eep_cmd_engine_tb;
  localparam int WC = 400;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0;
  logic so, so_en, wel_in = 1'b1, sts_wr_ok = 1'b1, prot_on = 1'b0;
  logic [6:0]  stat_in = 7'h2D;
  logic [11:0] pg_chk_addr;
  logic wel_set, latch_clr, flag_set, sts_wr, busy, cyc_done, pg_wr_ok;
  logic [7:0] sts_wdata;

  always #4 clk = ~clk;

  assign pg_wr_ok = !(prot_on && pg_chk_addr >= 12'hC00);

  eep_cmd_engine #(.WC_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_en(so_en), .stat_in(stat_in), .wel_in(wel_in),
    .sts_wr_ok(sts_wr_ok), .pg_wr_ok(pg_wr_ok), .pg_chk_addr(pg_chk_addr),
    .wel_set(wel_set), .latch_clr(latch_clr), .flag_set(flag_set),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .busy(busy), .cyc_done(cyc_done));

  int n_chk = 0, n_fail = 0;
  int n_wel = 0, n_clr = 0, n_flag = 0, n_sr = 0, n_rise = 0, n_done = 0;
  int run = 0, last_run = 0;
  logic busy_q = 1'b0;
  logic [7:0] sr_cap = '0;
  logic [7:0] model [4096];
  bit         known [4096];
  logic [7:0] txb [64];
  logic [7:0] rxb [64];
  bit m3 = 1'b0;

  always @(negedge clk) begin
    if (wel_set) n_wel++;
    if (latch_clr) n_clr++;
    if (flag_set) n_flag++;
    if (sts_wr) begin n_sr++; sr_cap = sts_wdata; end
    if (cyc_done) n_done++;
    if (busy && !busy_q) n_rise++;
    busy_q = busy;
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      if (m3) sck = 1'b0;
      si = tx[7-i];
      tick(H);
      rx[7-i] = so;
      sck = 1'b1;
      tick(H);
      if (!m3) sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cs_lo();
    sck = m3;
    tick(H);
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic cs_hi();
    tick(H);
    cs_n = 1'b1;
    tick(2*H);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xbyte(op, r); cs_hi();
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(4);
  endtask

  // sends a write of n bytes from txb, then eb stray bits
  task automatic do_write(input logic [15:0] a, input int n, input int eb);
    logic [7:0] r;
    cs_lo();
    xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) xbyte(txb[i], r);
    if (eb > 0) xbits(8'hA5, eb, r);
    cs_hi();
  endtask

  // bench view of the page wrap: offset is (start + i) mod 32 inside the page
  task automatic model_write(input logic [15:0] a, input int n);
    int base, off;
    base = int'(a[11:0]) & ~31;
    for (int i = 0; i < n; i++) begin
      off = (int'(a[4:0]) + i) % 32;
      model[base + off] = txb[i];
      known[base + off] = 1'b1;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_lo();
    xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) xbyte(8'h00, rxb[i]);
    cs_hi();
  endtask

  task automatic check_read(input string req, input logic [15:0] a, input int n);
    int idx;
    do_read(a, n);
    for (int i = 0; i < n; i++) begin
      idx = (int'(a[11:0]) + i) % 4096;
      if (known[idx]) chk(req, rxb[i], model[idx]);
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) txb[i] = 8'($urandom);
  endtask

  initial begin
    int r0;
    logic [7:0] r, s1, s2;
    void'($urandom(32'd7321));
    tick(10);
    rst_n = 1'b1;
    tick(5);
    chk("R2 reset so_en", so_en, 0);
    chk("R8 reset busy", busy, 0);

    // R11: chip select already low from reset, a whole command is clocked in
    xbyte(8'h06, r);
    cs_n = 1'b1; tick(2*H);
    chk("R11 no command before cs fall", n_wel, 0);

    // R1 strobes
    cmd(8'h06); chk("R1 set latch", n_wel, 1);
    cmd(8'h04); chk("R1 clear latch", n_clr, 1);
    cmd(8'h00); chk("R1 set flag", n_flag, 1);
    cs_lo(); xbyte(8'h06, r); xbits(8'h00, 1, r); cs_hi();
    chk("R1 nine bits cancel", n_wel, 1);
    cs_lo(); xbits(8'h06, 7, r); cs_hi();
    chk("R1 seven bits cancel", n_wel, 1);

    // R2 output enable follows chip select
    cs_lo(); tick(2);
    chk("R2 enabled while selected", so_en, 1);
    cs_hi();
    chk("R2 off after deselect", so_en, 0);

    // R3 status read, repeats, busy bit 0 clear
    cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s1); xbyte(8'h00, s2); cs_hi();
    chk("R3 status byte", s1, {7'h2D, 1'b0});
    chk("R3 status repeat", s2, {7'h2D, 1'b0});

    // R5/R8/R4: write with junk upper address bits, count busy cycles
    fill(3);
    r0 = n_done;
    do_write(16'hF123, 3, 0); model_write(16'hF123, 3);
    wait_idle();
    chk("R8 busy length", last_run, WC);
    chk("R8 one done pulse", n_done - r0, 1);
    check_read("R4 read masked address", 16'h0123, 3);

    // R5 page wrap with overwrite, then R4 top-of-array wrap
    fill(34);
    do_write(16'h0FFE, 34, 0); model_write(16'h0FFE, 34);
    wait_idle();
    fill(4);
    do_write(16'h0000, 4, 0); model_write(16'h0000, 4);
    wait_idle();
    check_read("R5 page wrap", 16'h0FE0, 32);
    check_read("R4 array wrap", 16'h0FFC, 8);

    // R6: stray bits after data, and no data at all
    fill(2);
    do_write(16'h0200, 2, 0); model_write(16'h0200, 2); wait_idle();
    r0 = n_rise;
    fill(2); do_write(16'h0200, 2, 3); wait_idle();
    chk("R6 partial byte no cycle", n_rise - r0, 0);
    do_write(16'h0200, 0, 0); wait_idle();
    chk("R6 no data no cycle", n_rise - r0, 0);
    check_read("R6 array unchanged", 16'h0200, 2);

    // R7: latch clear, protected page, allowed page
    wel_in = 1'b0; fill(2); do_write(16'h0200, 2, 0); wait_idle();
    chk("R7 latch clear drops write", n_rise - r0, 0);
    wel_in = 1'b1; prot_on = 1'b1;
    fill(2); do_write(16'h0C40, 2, 0); wait_idle();
    chk("R7 protected page drops write", n_rise - r0, 0);
    check_read("R7 array unchanged", 16'h0200, 2);
    fill(2); do_write(16'h0040, 2, 0); model_write(16'h0040, 2); wait_idle();
    chk("R7 open page writes", n_rise - r0, 1);
    prot_on = 1'b0;
    check_read("R7 open page data", 16'h0040, 2);

    // R9: commands during a cycle
    fill(1); do_write(16'h0300, 1, 0); model_write(16'h0300, 1);
    r0 = n_wel;
    cmd(8'h06);
    chk("R9 strobe blocked while busy", n_wel - r0, 0);
    cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s1); cs_hi();
    chk("R3 R9 status shows busy", s1, {7'h2D, 1'b1});
    wait_idle();
    check_read("R9 data after cycle", 16'h0300, 1);

    // R10 status write
    r0 = n_rise;
    cs_lo(); xbyte(8'h01, r); xbyte(8'h8C, r); cs_hi();
    chk("R10 status write strobe", n_sr, 1);
    chk("R10 status data", sr_cap, 8'h8C);
    wait_idle();
    chk("R10 cycle started", n_rise - r0, 1);
    sts_wr_ok = 1'b0;
    cs_lo(); xbyte(8'h01, r); xbyte(8'h11, r); cs_hi(); wait_idle();
    chk("R10 refused when locked", n_sr, 1);
    sts_wr_ok = 1'b1;
    cs_lo(); xbyte(8'h01, r); xbyte(8'h11, r); xbits(8'h00, 2, r); cs_hi(); wait_idle();
    chk("R10 stray bits cancel", n_sr, 1);

    // R12 clock mode 3
    m3 = 1'b1;
    check_read("R12 mode 3 read", 16'h0FFC, 8);
    cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s1); cs_hi();
    chk("R12 mode 3 status", s1, {7'h2D, 1'b0});
    m3 = 1'b0;

    // random writes and reads against the bench model
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom);
      n = 1 + int'($urandom % 40);
      fill(n);
      do_write(a, n, 0); model_write(a, n); wait_idle();
      check_read("R5 random page", {4'h0, a[11:5], 5'h00}, 32);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule